// File: doc/BRIEF.md
# Register Rename Map with Free List

This block is the rename stage of an out-of-order core. Each cycle it can accept one instruction with two architectural source registers and one architectural destination. It returns the physical registers that currently hold the sources. When the instruction writes a register, it also returns a newly allocated physical register for the destination, together with the physical register that the destination mapped to before. A later writer of the same architectural register always receives a different physical register, so write-after-write and write-after-read conflicts cannot arise.

Two copies of the map are kept. The speculative map changes at rename time. The committed map changes through the commit port. That same port returns the superseded physical register to the free list. A flush copies the committed map into the speculative map and rebuilds the free list, so every register allocated since the last commit becomes free again.

A small controller has three states. **RUN** accepts instructions. **STARVED** is entered when the free list becomes empty, and it holds off new instructions until a register is released. **RESTORE** lasts one cycle after a flush and accepts nothing. The transitions are:
- RUN→STARVED and RESTORE→STARVED happen when the free list will be empty.
- STARVED→RUN and RESTORE→RUN happen when the free list will be non-empty.
- Any state moves to RESTORE on flush.

Top module: `reg_rename`

## Requirements
- R1: After reset, architectural register i maps to physical register i, physical registers ARCH_REGS to PHYS_REGS-1 are free, the state is RUN (`in_ready`=1), and `out_valid`=0.
- R2: An instruction is accepted on a rising edge when `in_valid`=1, `in_ready`=1 and `flush`=0. Its results appear with `out_valid`=1 in the following cycle, and `out_src_a`/`out_src_b` are the speculative map entries of its sources at acceptance.
- R3: Sources are translated before the same instruction's destination is remapped, so an instruction whose source equals its destination reads the older mapping.
- R4: A writing instruction (`in_wr`=1) receives the lowest-numbered free physical register as `out_dst`. `out_prev` is the previous mapping of its destination, and the map entry is updated to `out_dst`.
- R5: Two writers of the same architectural register receive different physical registers, and `out_dst` never equals `out_prev`.
- R6: A non-writing instruction (`in_wr`=0) allocates nothing, leaves the map unchanged, and reports `out_wr`=0 with `out_dst`=`out_prev`=0.
- R7: When the free list is empty, `in_ready` is 0 and no instruction is accepted, even if `in_valid` is held at 1.
- R8: A commit (`cm_valid`=1) sets the committed entry for `cm_arch` to `cm_preg` and returns `cm_prev` to the free list. `in_ready` reflects the release in the next cycle, and the released register is then allocatable.
- R9: A flush copies the committed map (including a same-cycle commit) into the speculative map. Every physical register that is not in the committed map becomes free. `in_ready` is 0 for exactly one cycle afterwards.
- R10: A flush takes priority over a rename in the same cycle: that instruction is dropped and `out_valid` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Restore speculative state from committed state |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Rename can accept an instruction |
| in_src_a | input | AREG_W | First architectural source |
| in_src_b | input | AREG_W | Second architectural source |
| in_dst | input | AREG_W | Architectural destination |
| in_wr | input | 1 | Instruction writes its destination |
| out_valid | output | 1 | Renamed instruction present |
| out_src_a | output | PREG_W | Physical first source |
| out_src_b | output | PREG_W | Physical second source |
| out_wr | output | 1 | Renamed instruction writes a register |
| out_dst | output | PREG_W | Newly allocated physical destination |
| out_prev | output | PREG_W | Prior physical mapping of the destination |
| cm_valid | input | 1 | Commit of a writing instruction |
| cm_arch | input | AREG_W | Architectural destination being committed |
| cm_preg | input | PREG_W | Physical register becoming committed |
| cm_prev | input | PREG_W | Superseded physical register to release |

## Verification
Several properties are checked on every cycle:
- An allocation only happens while the free list holds an entry.
- A release never targets a register that is already free.
- A renamed destination differs from the prior mapping.
- A flush blocks input for one cycle and suppresses the next output.
- The speculative map equals the committed map right after a restore.

Other behaviour can only be shown by the bench's scenarios against its reference model:
- the lowest-free allocation order
- the source-before-destination read
- exhaustion followed by recovery after a release
- the exact contents of the map and the free list after a flush

// File: rtl/reg_rename_pkg.sv
package reg_rename_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_STARVED = 2'd1,
        ST_RESTORE = 2'd2
    } rn_state_e;

endpackage

// File: rtl/reg_rename_freelist.sv
module reg_rename_freelist #(
    parameter int ARCH_REGS = 8,
    parameter int PHYS_REGS = 16,
    localparam int PREG_W = $clog2(PHYS_REGS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc_en,
    input  logic                 rel_en,
    input  logic [PREG_W-1:0]    rel_idx,
    input  logic                 load_en,
    input  logic [PHYS_REGS-1:0] load_mask,
    output logic [PREG_W-1:0]    alloc_idx,
    output logic                 alloc_ok,
    output logic                 empty_next
);

    logic [PHYS_REGS-1:0] free_q;
    logic [PHYS_REGS-1:0] free_d;

    // lowest-numbered free register
    always_comb begin
        alloc_idx = '0;
        for (int i = PHYS_REGS - 1; i >= 0; i--) begin
            if (free_q[i]) alloc_idx = PREG_W'(i);
        end
    end

    assign alloc_ok = |free_q;

    always_comb begin
        free_d = free_q;
        if (load_en) begin
            free_d = load_mask;
        end else begin
            if (alloc_en) free_d[alloc_idx] = 1'b0;
            if (rel_en)   free_d[rel_idx]   = 1'b1;
        end
    end

    assign empty_next = (free_d == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PHYS_REGS; i++) free_q[i] <= (i >= ARCH_REGS);
        end else begin
            free_q <= free_d;
        end
    end

    // R7: allocation only from a non-empty list
    p_alloc_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> alloc_ok);

    // R8: a released register must not already be free
    p_release_not_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_en && !load_en) |-> !free_q[rel_idx]);

endmodule

// File: rtl/reg_rename_map.sv
module reg_rename_map #(
    parameter int ARCH_REGS = 8,
    parameter int PHYS_REGS = 16,
    localparam int AREG_W = $clog2(ARCH_REGS),
    localparam int PREG_W = $clog2(PHYS_REGS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AREG_W-1:0]    rd_a,
    input  logic [AREG_W-1:0]    rd_b,
    input  logic [AREG_W-1:0]    rd_dst,
    output logic [PREG_W-1:0]    rd_a_p,
    output logic [PREG_W-1:0]    rd_b_p,
    output logic [PREG_W-1:0]    rd_dst_p,
    input  logic                 wr_en,
    input  logic [AREG_W-1:0]    wr_arch,
    input  logic [PREG_W-1:0]    wr_preg,
    input  logic                 cm_en,
    input  logic [AREG_W-1:0]    cm_arch,
    input  logic [PREG_W-1:0]    cm_preg,
    input  logic                 restore,
    output logic [PHYS_REGS-1:0] restore_free
);

    logic [ARCH_REGS-1:0][PREG_W-1:0] spec_q, spec_d;
    logic [ARCH_REGS-1:0][PREG_W-1:0] comm_q, comm_d;
    logic [PHYS_REGS-1:0]             used;

    assign rd_a_p   = spec_q[rd_a];
    assign rd_b_p   = spec_q[rd_b];
    assign rd_dst_p = spec_q[rd_dst];

    always_comb begin
        comm_d = comm_q;
        if (cm_en) comm_d[cm_arch] = cm_preg;
    end

    always_comb begin
        used = '0;
        for (int i = 0; i < ARCH_REGS; i++) used[comm_d[i]] = 1'b1;
    end

    assign restore_free = ~used;

    always_comb begin
        spec_d = spec_q;
        if (restore)    spec_d = comm_d;
        else if (wr_en) spec_d[wr_arch] = wr_preg;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ARCH_REGS; i++) begin
                spec_q[i] <= PREG_W'(i);
                comm_q[i] <= PREG_W'(i);
            end
        end else begin
            spec_q <= spec_d;
            comm_q <= comm_d;
        end
    end

    // R9: after a restore the speculative map equals the committed map
    p_restore_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> (spec_q == comm_q));

endmodule

// File: rtl/reg_rename_ctrl.sv
module reg_rename_ctrl
    import reg_rename_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic flush,
    input  logic empty_next,
    output logic in_ready,
    output logic fire
);

    rn_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (flush)           state_d = ST_RESTORE;
                else if (empty_next) state_d = ST_STARVED;
            end
            ST_STARVED: begin
                if (flush)            state_d = ST_RESTORE;
                else if (!empty_next) state_d = ST_RUN;
            end
            ST_RESTORE: begin
                if (flush)           state_d = ST_RESTORE;
                else if (empty_next) state_d = ST_STARVED;
                else                 state_d = ST_RUN;
            end
            default: state_d = ST_RESTORE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        in_ready = (state_q == ST_RUN);
        fire     = in_valid && in_ready && !flush;
    end

    // R9: input is blocked in the cycle after a flush
    p_restore_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !in_ready);

    // R9: restore lasts a single cycle without another flush
    p_restore_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESTORE && !flush) |=> (state_q != ST_RESTORE));

endmodule

// File: rtl/reg_rename.sv
module reg_rename #(
    parameter int ARCH_REGS = 8,
    parameter int PHYS_REGS = 16,
    localparam int AREG_W = $clog2(ARCH_REGS),
    localparam int PREG_W = $clog2(PHYS_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [AREG_W-1:0] in_src_a,
    input  logic [AREG_W-1:0] in_src_b,
    input  logic [AREG_W-1:0] in_dst,
    input  logic              in_wr,
    output logic              out_valid,
    output logic [PREG_W-1:0] out_src_a,
    output logic [PREG_W-1:0] out_src_b,
    output logic              out_wr,
    output logic [PREG_W-1:0] out_dst,
    output logic [PREG_W-1:0] out_prev,
    input  logic              cm_valid,
    input  logic [AREG_W-1:0] cm_arch,
    input  logic [PREG_W-1:0] cm_preg,
    input  logic [PREG_W-1:0] cm_prev
);

    logic                 fire;
    logic                 alloc_en;
    logic                 alloc_ok;
    logic                 empty_next;
    logic [PREG_W-1:0]    alloc_idx;
    logic [PREG_W-1:0]    map_a, map_b, map_dst;
    logic [PHYS_REGS-1:0] restore_free;

    assign alloc_en = fire && in_wr;

    reg_rename_ctrl i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .flush      (flush),
        .empty_next (empty_next),
        .in_ready   (in_ready),
        .fire       (fire)
    );

    reg_rename_map #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) i_map (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_a         (in_src_a),
        .rd_b         (in_src_b),
        .rd_dst       (in_dst),
        .rd_a_p       (map_a),
        .rd_b_p       (map_b),
        .rd_dst_p     (map_dst),
        .wr_en        (alloc_en),
        .wr_arch      (in_dst),
        .wr_preg      (alloc_idx),
        .cm_en        (cm_valid),
        .cm_arch      (cm_arch),
        .cm_preg      (cm_preg),
        .restore      (flush),
        .restore_free (restore_free)
    );

    reg_rename_freelist #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) i_free (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (alloc_en),
        .rel_en     (cm_valid),
        .rel_idx    (cm_prev),
        .load_en    (flush),
        .load_mask  (restore_free),
        .alloc_idx  (alloc_idx),
        .alloc_ok   (alloc_ok),
        .empty_next (empty_next)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_src_a <= '0;
            out_src_b <= '0;
            out_wr    <= 1'b0;
            out_dst   <= '0;
            out_prev  <= '0;
        end else begin
            out_valid <= fire;
            if (fire) begin
                out_src_a <= map_a;
                out_src_b <= map_b;
                out_wr    <= in_wr;
                out_dst   <= in_wr ? alloc_idx : '0;
                out_prev  <= in_wr ? map_dst : '0;
            end
        end
    end

    // R5: a fresh destination never equals the mapping it replaces
    p_fresh_dest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_wr) |-> (out_dst != out_prev));

    // R10: a flush suppresses the next output
    p_flush_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid);

    // R7: nothing is accepted while ready is low
    p_no_accept_starved_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |=> !out_valid);

endmodule

// File: tb/test_reg_rename.sv
`timescale 1ns/1ps
module test_reg_rename;

    localparam int ARCH = 8;
    localparam int PHYS = 16;
    localparam int AW = $clog2(ARCH);
    localparam int PW = $clog2(PHYS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [AW-1:0] in_src_a = '0, in_src_b = '0, in_dst = '0;
    logic          in_wr = 1'b0;
    logic          out_valid;
    logic [PW-1:0] out_src_a, out_src_b, out_dst, out_prev;
    logic          out_wr;
    logic          cm_valid = 1'b0;
    logic [AW-1:0] cm_arch = '0;
    logic [PW-1:0] cm_preg = '0, cm_prev = '0;

    always #4 clk = ~clk;

    reg_rename #(.ARCH_REGS(ARCH), .PHYS_REGS(PHYS)) i_reg_rename (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst), .in_wr(in_wr),
        .out_valid(out_valid), .out_src_a(out_src_a), .out_src_b(out_src_b),
        .out_wr(out_wr), .out_dst(out_dst), .out_prev(out_prev),
        .cm_valid(cm_valid), .cm_arch(cm_arch), .cm_preg(cm_preg), .cm_prev(cm_prev)
    );

    typedef struct { int a; int b; int wr; int dst; int prev; string tag; } exp_t;
    typedef struct { int arch; int preg; int prev; } cm_t;

    exp_t exp_q[$];
    cm_t  cm_q[$];
    int   m_map [ARCH];
    int   m_cmap[ARCH];
    bit   m_free[PHYS];
    int   errors = 0;
    int   checks = 0;
    bit   done = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int lowest_free();
        for (int i = 0; i < PHYS; i++) if (m_free[i]) return i;
        return -1;
    endfunction

    // driver: called and returns at a falling edge
    task automatic issue(input int a, input int b, input int d, input bit w, input string tag);
        exp_t e;
        while (!in_ready) @(negedge clk);
        e.a = m_map[a]; e.b = m_map[b]; e.wr = w; e.tag = tag;
        if (w) begin
            cm_t c;
            e.dst = lowest_free();
            e.prev = m_map[d];
            m_free[e.dst] = 1'b0;
            m_map[d] = e.dst;
            c.arch = d; c.preg = e.dst; c.prev = e.prev;
            cm_q.push_back(c);
        end else begin
            e.dst = 0; e.prev = 0;
        end
        exp_q.push_back(e);
        in_valid = 1'b1; in_src_a = AW'(a); in_src_b = AW'(b); in_dst = AW'(d); in_wr = w;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic commit_next();
        cm_t c;
        c = cm_q.pop_front();
        m_cmap[c.arch] = c.preg;
        m_free[c.prev] = 1'b1;
        cm_valid = 1'b1; cm_arch = AW'(c.arch); cm_preg = PW'(c.preg); cm_prev = PW'(c.prev);
        @(negedge clk);
        cm_valid = 1'b0;
    endtask

    // monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7/R10 unexpected output", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(out_src_a == PW'(e.a), {e.tag, " src_a"}, int'(out_src_a), e.a);
                check(out_src_b == PW'(e.b), {e.tag, " src_b"}, int'(out_src_b), e.b);
                check(out_wr == e.wr[0] && out_dst == PW'(e.dst), {e.tag, " dst"}, int'(out_dst), e.dst);
                check(out_prev == PW'(e.prev), {e.tag, " prev"}, int'(out_prev), e.prev);
            end
        end
    end

    initial begin
        for (int i = 0; i < ARCH; i++) begin m_map[i] = i; m_cmap[i] = i; end
        for (int i = 0; i < PHYS; i++) m_free[i] = (i >= ARCH);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
        check(out_valid == 1'b0, "R1 no output after reset", int'(out_valid), 0);

        issue(3, 5, 0, 1'b0, "R1 R2 R6 identity read");
        issue(1, 4, 1, 1'b1, "R3 R4 self-source write");
        issue(1, 2, 1, 1'b1, "R5 second writer");
        issue(1, 6, 1, 1'b0, "R6 non-writer");
        issue(1, 1, 0, 1'b0, "R6 map unchanged");
        for (int d = 2; d < ARCH; d++) issue(d, 0, d, 1'b1, "R4 fill");
        @(negedge clk);
        check(in_ready == 1'b0, "R7 ready low when empty", int'(in_ready), 0);
        in_valid = 1'b1; in_src_a = 3'd1; in_dst = 3'd1; in_wr = 1'b1;
        repeat (2) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R7 held instruction not taken", int'(out_valid), 0);
        end
        in_valid = 1'b0;

        commit_next();
        check(in_ready == 1'b1, "R8 ready after release", int'(in_ready), 1);
        issue(3, 1, 3, 1'b1, "R8 reuse released");
        commit_next();
        @(negedge clk);
        @(negedge clk);

        // R10: flush and an instruction in the same cycle
        for (int i = 0; i < ARCH; i++) m_map[i] = m_cmap[i];
        for (int i = 0; i < PHYS; i++) m_free[i] = 1'b1;
        for (int i = 0; i < ARCH; i++) m_free[m_cmap[i]] = 1'b0;
        cm_q.delete();
        flush = 1'b1; in_valid = 1'b1; in_src_a = 3'd2; in_dst = 3'd2; in_wr = 1'b1;
        @(negedge clk);
        flush = 1'b0; in_valid = 1'b0;
        check(in_ready == 1'b0, "R9 restore cycle blocks", int'(in_ready), 0);
        check(out_valid == 1'b0, "R10 flushed instruction dropped", int'(out_valid), 0);
        @(negedge clk);
        check(in_ready == 1'b1, "R9 ready after restore", int'(in_ready), 1);
        issue(1, 2, 5, 1'b1, "R9 committed map restored");
        issue(5, 7, 6, 1'b1, "R9 free list rebuilt");
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R2 all results seen", exp_q.size(), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule